// File: doc/BRIEF.md
# Programmable Waveform Bus Master

This block masters an external parallel bus. The bus protocol is not fixed in logic: it is set by a short table of descriptor words. Each descriptor holds the levels for six control outputs, a condition on six ready inputs that must be met before the engine moves on, and two side effects that fire when the engine leaves that state. One side effect steps the data FIFO. The other steps a nine-bit bus address. The descriptors run from slot 0 up to a slot marked last, and that sequence forms one transaction.

A one-cycle start pulse loads a 32-bit transaction count and a starting address. The engine then repeats the waveform until the count has been used up. It stalls whenever a descriptor asks for a FIFO step and the FIFO cannot supply or take a value. When the last state of the final transaction finishes, the engine goes idle, drives a programmable idle pattern on the control outputs and pulses done. The data path is 8 or 16 bits wide. The descriptor table comes in as a flat input vector, because descriptor loading happens outside this block.

Top module: `wave_bus_master`

## Requirements
- R1: After reset, busy, done and fifo_adv are 0, count_left is 0, and ctl_out equals idle_ctl.
- R2: A start pulse while idle with a nonzero xfer_count raises busy on the next cycle. That cycle is in slot 0, with addr_out equal to addr_init and count_left equal to xfer_count.
- R3: While busy, ctl_out equals bits [5:0] of the current descriptor. While idle, ctl_out equals idle_ctl.
- R4: Descriptor bit 13 set means wait. The state is then held until the ready condition is true. If bit 12 is 0, every ready input selected by mask bits [11:6] must be high, and an empty mask counts as true. If bit 12 is 1, at least one selected input must be high. With bit 13 clear, the state lasts exactly one cycle.
- R5: Descriptor bit 14 requests a FIFO step. The state does not advance while fifo_ok is low. fifo_adv is high only in the cycle in which such a state advances.
- R6: When a state with bit 15 set advances, addr_out increases by 1 on the next cycle, wrapping from 511 to 0.
- R7: A state advances past the end of a transaction if bit 16 is set or it is slot NSTATES-1. count_left then drops by 1. If the count is not used up, the next state is slot 0.
- R8: When the final transaction ends, done is high for exactly one cycle, busy is low in that same cycle, and ctl_out returns to idle_ctl.
- R9: A start pulse with xfer_count equal to 0 produces a done pulse on the next cycle and no busy cycle at all.
- R10: A start pulse while busy has no effect on the state sequence, the address or the count.
- R11: bus_dout equals fifo_din when wide_mode is 1. When wide_mode is 0, bus_dout is the low byte of fifo_din with the upper byte zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | One-cycle trigger pulse |
| xfer_count | input | 32 | Number of transactions to run |
| addr_init | input | 9 | Starting bus address |
| idle_ctl | input | 6 | Control levels while idle |
| desc_flat | input | 136 | Eight 17-bit descriptors, slot 0 in the low bits |
| rdy_in | input | 6 | Ready inputs |
| fifo_ok | input | 1 | FIFO can supply or take one value |
| wide_mode | input | 1 | 1 selects 16-bit data, 0 selects 8-bit data |
| fifo_din | input | 16 | Data value at the FIFO head |
| ctl_out | output | 6 | Control outputs |
| addr_out | output | 9 | Bus address |
| fifo_adv | output | 1 | FIFO step strobe |
| bus_dout | output | 16 | Data driven to the bus |
| busy | output | 1 | Waveform running |
| done | output | 1 | Completion pulse |
| count_left | output | 32 | Transactions remaining |

## Verification
The directed waveforms isolate one feature each:
- Fixed-length states with no waits show the slot order and the count handling.
- A partially then fully satisfied AND mask, and an OR mask, show the two ways of combining the ready inputs.
- Holding fifo_ok low on a FIFO-step state separates a stall from normal advance.
- An address start just below the top of the range shows the wrap.
- A zero count, and a second start pulse during a run, cover the trigger corner cases.

Random descriptor tables with random ready patterns, FIFO availability and data width then mix these features. Each cycle of those runs is compared against a cycle model held in the bench.

// File: rtl/wave_bus_master.sv
module wave_bus_master #(
  parameter int NSTATES = 8,
  parameter int NCTL    = 6,
  parameter int NRDY    = 6,
  parameter int AW      = 9,
  parameter int CW      = 32,
  parameter int DWID    = 16,
  localparam int DESCW  = NCTL + NRDY + 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [CW-1:0]            xfer_count,
  input  logic [AW-1:0]            addr_init,
  input  logic [NCTL-1:0]          idle_ctl,
  input  logic [NSTATES*DESCW-1:0] desc_flat,
  input  logic [NRDY-1:0]          rdy_in,
  input  logic                     fifo_ok,
  input  logic                     wide_mode,
  input  logic [DWID-1:0]          fifo_din,
  output logic [NCTL-1:0]          ctl_out,
  output logic [AW-1:0]            addr_out,
  output logic                     fifo_adv,
  output logic [DWID-1:0]          bus_dout,
  output logic                     busy,
  output logic                     done,
  output logic [CW-1:0]            count_left
);
  localparam int SW   = (NSTATES > 1) ? $clog2(NSTATES) : 1;
  localparam int HW   = DWID / 2;
  localparam int B_OR = NCTL + NRDY;
  localparam int B_WT = B_OR + 1;
  localparam int B_FA = B_OR + 2;
  localparam int B_AI = B_OR + 3;
  localparam int B_LS = B_OR + 4;

  logic [SW-1:0]    st;
  logic             busy_q, done_q;
  logic [CW-1:0]    cnt_q;
  logic [AW-1:0]    addr_q;
  logic [DESCW-1:0] cur;
  logic [NRDY-1:0]  mask;
  logic             cond, step, final_st, finish;

  assign cur      = desc_flat[st*DESCW +: DESCW];
  assign mask     = cur[NCTL +: NRDY];
  assign cond     = cur[B_OR] ? |(rdy_in & mask) : &(rdy_in | ~mask);
  assign step     = busy_q && (!cur[B_WT] || cond) && (!cur[B_FA] || fifo_ok);
  assign final_st = cur[B_LS] || (st == SW'(NSTATES - 1));
  assign finish   = step && final_st && (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          if (xfer_count == '0) done_q <= 1'b1;
          else begin
            busy_q <= 1'b1;
            st     <= '0;
            cnt_q  <= xfer_count;
            addr_q <= addr_init;
          end
        end
      end else if (step) begin
        if (cur[B_AI]) addr_q <= addr_q + 1'b1;
        if (final_st) begin
          cnt_q <= cnt_q - 1'b1;
          st    <= '0;
          if (cnt_q == CW'(1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end else st <= st + 1'b1;
      end
    end
  end

  assign ctl_out    = busy_q ? cur[NCTL-1:0] : idle_ctl;
  assign addr_out   = addr_q;
  assign fifo_adv   = step && cur[B_FA];
  assign bus_dout   = wide_mode ? fifo_din : {{(DWID-HW){1'b0}}, fifo_din[HW-1:0]};
  assign busy       = busy_q;
  assign done       = done_q;
  assign count_left = cnt_q;

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R8
  finish_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (done && !busy));
  // R5
  fifo_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur[B_FA] && !fifo_ok) |=> ($stable(st) && $stable(addr_out) && busy));
  // R9
  zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && xfer_count == '0) |=> (done && !busy));
  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cur[B_AI]) |=> (addr_out == $past(addr_out) + 1'b1));
  // R10
  start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step && start) |=> ($stable(count_left) && busy));
endmodule

// File: tb/wave_bus_master_test.sv
`timescale 1ns/1ps
module wave_bus_master_test;
  localparam int NS = 8;
  localparam int DW = 17;

  logic clk = 0, rst_n = 0, start = 0, fifo_ok = 1, wide_mode = 1;
  logic [31:0] xfer_count = 0;
  logic [8:0]  addr_init = 0;
  logic [5:0]  idle_ctl = 6'h2A, rdy_in = 0;
  logic [15:0] fifo_din = 0;
  logic [DW-1:0] desc [NS];
  logic [NS*DW-1:0] desc_flat;
  logic [5:0]  ctl_out;
  logic [8:0]  addr_out;
  logic        fifo_adv, busy, done;
  logic [15:0] bus_dout;
  logic [31:0] count_left;

  always #10 clk = ~clk;
  always_comb for (int i = 0; i < NS; i++) desc_flat[i*DW +: DW] = desc[i];

  wave_bus_master uut (
    .clk(clk), .rst_n(rst_n), .start(start), .xfer_count(xfer_count),
    .addr_init(addr_init), .idle_ctl(idle_ctl), .desc_flat(desc_flat),
    .rdy_in(rdy_in), .fifo_ok(fifo_ok), .wide_mode(wide_mode), .fifo_din(fifo_din),
    .ctl_out(ctl_out), .addr_out(addr_out), .fifo_adv(fifo_adv), .bus_dout(bus_dout),
    .busy(busy), .done(done), .count_left(count_left));

  int checks = 0, fails = 0;
  logic m_busy = 0, m_done = 0;
  logic [2:0] m_st = 0;
  logic [31:0] m_cnt = 0;
  logic [8:0] m_addr = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] mkd(input logic [5:0] c, input logic [5:0] m,
      input bit o, input bit w, input bit f, input bit a, input bit l);
    return {l, a, f, w, o, m, c};
  endfunction

  function automatic bit rdy_met(input logic [DW-1:0] d, input logic [5:0] r);
    if (d[12]) return (r & d[11:6]) != 0;
    return (r & d[11:6]) == d[11:6];
  endfunction

  function automatic logic [15:0] exp_bus(input bit w, input logic [15:0] v);
    return w ? v : {8'h00, v[7:0]};
  endfunction

  task automatic tick();
    logic [DW-1:0] d;
    bit stp, fin;
    logic n_busy, n_done;
    logic [2:0] n_st;
    logic [31:0] n_cnt;
    logic [8:0] n_addr;
    #2;
    d = desc[m_st];
    stp = m_busy && (!d[13] || rdy_met(d, rdy_in)) && (!d[14] || fifo_ok);
    fin = d[16] || (m_st == 3'(NS - 1));
    chk(ctl_out == (m_busy ? d[5:0] : idle_ctl), "R3 ctl_out", ctl_out, m_busy ? d[5:0] : idle_ctl);
    chk(addr_out == m_addr, "R6 addr_out", addr_out, m_addr);
    chk(busy == m_busy, "R2 busy", busy, m_busy);
    chk(done == m_done, "R8 done", done, m_done);
    chk(fifo_adv == (stp && d[14]), "R5 fifo_adv", fifo_adv, stp && d[14]);
    chk(count_left == m_cnt, "R7 count_left", count_left, m_cnt);
    chk(bus_dout == exp_bus(wide_mode, fifo_din), "R11 bus_dout", bus_dout, exp_bus(wide_mode, fifo_din));
    n_busy = m_busy; n_done = 0; n_st = m_st; n_cnt = m_cnt; n_addr = m_addr;
    if (!m_busy) begin
      if (start) begin
        if (xfer_count == 0) n_done = 1;
        else begin n_busy = 1; n_st = 0; n_cnt = xfer_count; n_addr = addr_init; end
      end
    end else if (stp) begin
      if (d[15]) n_addr = m_addr + 1;
      if (fin) begin
        n_cnt = m_cnt - 1; n_st = 0;
        if (m_cnt == 1) begin n_busy = 0; n_done = 1; end
      end else n_st = m_st + 1;
    end
    @(posedge clk);
    m_busy = n_busy; m_done = n_done; m_st = n_st; m_cnt = n_cnt; m_addr = n_addr;
    @(negedge clk);
  endtask

  task automatic kick(input logic [31:0] n, input logic [8:0] a);
    xfer_count = n; addr_init = a; start = 1;
    tick();
    start = 0;
  endtask

  task automatic run_out(input bit rnd);
    for (int i = 0; i < 4000 && (m_busy || m_done); i++) begin
      if (rnd) begin
        rdy_in = 6'($urandom | $urandom);
        fifo_ok = ($urandom % 4) != 0;
        fifo_din = 16'($urandom);
        wide_mode = $urandom % 2;
      end
      tick();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NS; i++) desc[i] = '0;
    @(negedge clk);
    #2;
    chk(busy == 0 && done == 0 && fifo_adv == 0, "R1 reset flags", {busy, done, fifo_adv}, 0);
    chk(ctl_out == idle_ctl, "R1 reset ctl", ctl_out, idle_ctl);
    chk(count_left == 0, "R1 reset count", count_left, 0);
    @(negedge clk);
    rst_n = 1;
    tick();

    // R9 zero count
    kick(0, 9'd5);
    chk(done == 1 && busy == 0, "R9 zero count done", {done, busy}, 2'b10);
    tick();
    chk(busy == 0 && done == 0, "R9 no bus cycles", {busy, done}, 0);

    // R3 R7 fixed three-state waveform, two transactions
    desc[0] = mkd(6'h01, 0, 0, 0, 0, 1, 0);
    desc[1] = mkd(6'h12, 0, 0, 0, 0, 0, 0);
    desc[2] = mkd(6'h3C, 0, 0, 0, 0, 1, 1);
    kick(2, 9'd100);
    chk(busy == 1 && count_left == 2, "R2 start loads count", count_left, 2);
    chk(ctl_out == 6'h01, "R3 slot0 pattern", ctl_out, 6'h01);
    tick(); tick(); tick();
    chk(count_left == 1 && ctl_out == 6'h01, "R7 repeat from slot0", {count_left[5:0], ctl_out}, {6'd1, 6'h01});
    run_out(0);
    chk(addr_out == 9'd104 && ctl_out == idle_ctl, "R8 idle after finish", addr_out, 104);

    // R4 AND wait and OR wait
    desc[0] = mkd(6'h05, 6'b001010, 0, 1, 0, 0, 0);
    desc[1] = mkd(6'h06, 6'b110000, 1, 1, 0, 0, 1);
    rdy_in = 6'b000010;
    kick(1, 0);
    tick(); tick();
    chk(ctl_out == 6'h05, "R4 AND partial holds", ctl_out, 6'h05);
    rdy_in = 6'b001010;
    tick();
    chk(ctl_out == 6'h06, "R4 AND met advances", ctl_out, 6'h06);
    rdy_in = 6'b001111;
    tick(); tick();
    chk(ctl_out == 6'h06 && busy, "R4 OR unmet holds", ctl_out, 6'h06);
    rdy_in = 6'b100000;
    tick();
    chk(done == 1, "R4 OR met finishes", done, 1);
    run_out(0);

    // R4 empty AND mask counts as true
    desc[0] = mkd(6'h09, 0, 0, 1, 0, 0, 1);
    rdy_in = 0;
    kick(1, 0);
    tick();
    chk(done == 1, "R4 empty mask passes", done, 1);
    run_out(0);

    // R5 FIFO stall
    desc[0] = mkd(6'h11, 0, 0, 0, 1, 1, 1);
    fifo_ok = 0;
    kick(1, 9'd7);
    tick(); tick();
    chk(busy && addr_out == 9'd7 && fifo_adv == 0, "R5 stall holds", addr_out, 7);
    fifo_ok = 1;
    #2;
    chk(fifo_adv == 1, "R5 strobe on advance", fifo_adv, 1);
    run_out(0);

    // R6 address wrap
    desc[0] = mkd(6'h21, 0, 0, 0, 0, 1, 1);
    kick(3, 9'd510);
    run_out(0);
    chk(addr_out == 9'd1, "R6 wrap past 511", addr_out, 1);

    // R10 start while busy
    desc[0] = mkd(6'h03, 6'b000001, 0, 1, 0, 0, 1);
    rdy_in = 0;
    kick(2, 9'd40);
    tick();
    xfer_count = 9; addr_init = 9'd300; start = 1;
    tick();
    start = 0;
    chk(count_left == 2 && addr_out == 9'd40, "R10 start ignored", count_left, 2);
    rdy_in = 6'h3F;
    run_out(0);

    // R11 width modes
    fifo_din = 16'hBEEF; wide_mode = 0;
    #2;
    chk(bus_dout == 16'h00EF, "R11 narrow", bus_dout, 16'h00EF);
    wide_mode = 1;
    #2;
    chk(bus_dout == 16'hBEEF, "R11 wide", bus_dout, 16'hBEEF);
    tick();

    // random waveforms
    for (int t = 0; t < 30; t++) begin
      for (int i = 0; i < NS; i++) begin
        desc[i] = DW'($urandom);
        if (desc[i][12] && desc[i][11:6] == 0) desc[i][6] = 1;
        if (($urandom % 3) == 0) desc[i][16] = 1;
      end
      idle_ctl = 6'($urandom);
      kick(($urandom % 4), 9'($urandom));
      if ((t % 5) == 0) begin start = 1; tick(); start = 0; end
      run_out(1);
      tick();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule